// File: doc/BRIEF.md
# Stack and Operand Address Unit

This block sits between the decoder and the data RAM of a small 8-bit accumulator core. Each accepted operation arrives with a 3-bit mode, the second instruction byte, the X index value, the accumulator and the return address. In the same cycle, the block produces the RAM address, byte-lane enables, read and write strobes and write data. It also owns the data stack pointer and the program stack pointer. Both pointers update on the next clock edge.

The data stack grows downward. A push decrements the pointer first and then stores the byte. A pop reads first and then increments. All pointer arithmetic is modulo 256, so a push on an empty stack lands in the top RAM byte.

The program stack works the other way round. A call stores a two-byte return address at the pointer and then advances the pointer by two. A return steps back by two and reads that pair. Loading the data stack pointer is an exchange with the accumulator.

Top module: `stk_addr_unit`

## Requirements
- R1: After synchronous reset, both stack pointers read 0x00. No read or write strobe is active while op_valid is low.
- R2: Mode 0 (immediate) drives imm_valid high and imm_out equal to the instruction byte, with ram_rd and ram_wr both low.
- R3: Mode 1 (direct) uses the instruction byte unchanged as ram_addr with ram_be=01. If op_store is 1 it writes the accumulator on lane 0; otherwise it reads.
- R4: Mode 2 (indexed) addresses (instruction byte + X) mod 256, with the same read/write choice and lane enable as R3.
- R5: Mode 3 (push) writes the accumulator on lane 0 at (DSP-1) mod 256 with ram_be=01. DSP takes that value on the next edge, so a push at DSP=0x00 writes 0xFF.
- R6: Mode 4 (pop) reads lane 0 at DSP and presents it on rd_data. DSP becomes (DSP+1) mod 256 on the next edge, so 0xFF goes to 0x00.
- R7: Mode 5 (call) writes with ram_be=11 at PSP. Lane 0 (address PSP) holds return-address bits 7:0 and lane 1 (address PSP+1) holds bits 15:8. PSP then becomes PSP+2.
- R8: Mode 6 (return) reads with ram_be=11 at (PSP-2) mod 256. It raises pc_load with pc_restore={lane 1, lane 0}, and PSP becomes PSP-2.
- R9: Mode 7 (swap) presents the current DSP on acc_out with acc_load high and no RAM access. DSP takes acc_in on the next edge.
- R10: With op_valid low, no strobe is driven and neither pointer changes, whatever the mode inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | One operation accepted this cycle |
| op_mode | input | 3 | Operation mode, encoding in R2 to R9 |
| op_store | input | 1 | Direct/indexed: 1 writes, 0 reads |
| op_byte | input | 8 | Second instruction byte |
| x_idx | input | 8 | X index register |
| acc_in | input | 8 | Accumulator value |
| pc_ret | input | 16 | Return address stored by a call |
| ram_rdata | input | 16 | RAM read data, lane 1 in bits 15:8 |
| ram_addr | output | 8 | RAM address of lane 0 (lane 1 is +1) |
| ram_be | output | 2 | Byte-lane enables |
| ram_rd | output | 1 | Read strobe |
| ram_wr | output | 1 | Write strobe |
| ram_wdata | output | 16 | Write data, lane 1 in bits 15:8 |
| imm_valid | output | 1 | Immediate operand present |
| imm_out | output | 8 | Immediate operand |
| rd_data | output | 8 | Lane 0 read byte for pop and loads |
| acc_load | output | 1 | Accumulator takes acc_out |
| acc_out | output | 8 | Old DSP during swap |
| pc_load | output | 1 | Program counter takes pc_restore |
| pc_restore | output | 16 | Return address read back |
| dsp_q | output | 8 | Data stack pointer |
| psp_q | output | 8 | Program stack pointer |

## Verification
The hardest states to reach are the pointer wrap points: DSP at 0x00 before a push, DSP at 0xFF before a pop, and PSP at 0x00 before a return. The first arises straight from reset. The bench pushes on the empty stack and checks the write at 0xFF, then pops twice to cross 0xFF back to 0x00. For the program stack it issues a return at PSP=0 to land on 0xFE, then nests calls and returns to check byte order. Swaps place DSP at chosen values so that push addresses away from the top can be confirmed.

// File: rtl/stk_pkg.sv
// Shared operation encoding for the stack and operand address unit.
package stk_pkg;
    typedef enum logic [2:0] {
        OP_IMM  = 3'd0,
        OP_DIR  = 3'd1,
        OP_IDX  = 3'd2,
        OP_PUSH = 3'd3,
        OP_POP  = 3'd4,
        OP_CALL = 3'd5,
        OP_RET  = 3'd6,
        OP_SWAP = 3'd7
    } stk_op_e;
endpackage

// File: rtl/stk_operand_addr.sv
// Operand address former.
// Direct mode passes the base through; indexed mode adds the index modulo 2**AW.
// Assumes base and index have equal width. Purely combinational.
module stk_operand_addr #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] idx_i,
    input  logic          indexed_i,
    output logic [AW-1:0] addr_o
);
    // Select the plain base or the wrapped sum.
    always_comb begin
        if (indexed_i) addr_o = base_i + idx_i;
        else           addr_o = base_i;
    end
endmodule

// File: rtl/stk_dsp_unit.sv
// Data stack pointer.
// A push decrements before the access, a pop increments after it, and a swap loads a new value.
// Assumes at most one enable per cycle. Arithmetic wraps silently.
module stk_dsp_unit #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          pop_en,
    input  logic          swap_en,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] dsp_q,
    output logic [AW-1:0] access_addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] dsp_dec;
    logic [AW-1:0] dsp_inc;

    // Neighbouring pointer values.
    always_comb begin
        dsp_dec = dsp_q - ONE;
        dsp_inc = dsp_q + ONE;
    end

    // Push addresses the decremented pointer; every other access uses the current one.
    always_comb begin
        access_addr = push_en ? dsp_dec : dsp_q;
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)       dsp_q <= '0;
        else if (push_en) dsp_q <= dsp_dec;
        else if (pop_en)  dsp_q <= dsp_inc;
        else if (swap_en) dsp_q <= load_val;
    end

    // R5
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> dsp_q == AW'($past(dsp_q) - ONE));
    // R6
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> dsp_q == AW'($past(dsp_q) + ONE));
    // R9
    swap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |=> dsp_q == $past(load_val));
    // R10
    dsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_en || pop_en || swap_en) |=> $stable(dsp_q));
    // R10
    dsp_one_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_en, pop_en, swap_en}));
endmodule

// File: rtl/stk_psp_unit.sv
// Program stack pointer.
// A call stores at the pointer and then advances it by STEP; a return steps back by STEP and reads there.
// Assumes call and return are never requested together.
module stk_psp_unit #(
    parameter int AW   = 8,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_en,
    input  logic          ret_en,
    output logic [AW-1:0] psp_q,
    output logic [AW-1:0] frame_addr
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] psp_up;
    logic [AW-1:0] psp_dn;

    // Frame boundaries around the pointer.
    always_comb begin
        psp_up = psp_q + STEP_V;
        psp_dn = psp_q - STEP_V;
    end

    // A return reads the frame below; a call writes at the pointer.
    always_comb begin
        frame_addr = ret_en ? psp_dn : psp_q;
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)       psp_q <= '0;
        else if (call_en) psp_q <= psp_up;
        else if (ret_en)  psp_q <= psp_dn;
    end

    // R7
    call_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_en |=> psp_q == AW'($past(psp_q) + STEP_V));
    // R8
    ret_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |=> psp_q == AW'($past(psp_q) - STEP_V));
    // R10
    psp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(call_en || ret_en) |=> $stable(psp_q));
endmodule

// File: rtl/stk_addr_unit.sv
// Stack and operand address unit (top).
// Decodes one operation per valid cycle into a RAM access driven in the same cycle,
// and keeps the data and program stack pointers, which update at the next edge.
// Assumes ADDR_W equals DATA_W (the swap path) and PC_W is a whole number of data bytes.
module stk_addr_unit
    import stk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int PC_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_mode,
    input  logic              op_store,
    input  logic [DATA_W-1:0] op_byte,
    input  logic [ADDR_W-1:0] x_idx,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [PC_W-1:0]   pc_ret,
    input  logic [PC_W-1:0]   ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [PC_W/DATA_W-1:0] ram_be,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [PC_W-1:0]   ram_wdata,
    output logic              imm_valid,
    output logic [DATA_W-1:0] imm_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_load,
    output logic [DATA_W-1:0] acc_out,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_restore,
    output logic [ADDR_W-1:0] dsp_q,
    output logic [ADDR_W-1:0] psp_q
);
    localparam int LANES = PC_W / DATA_W;
    localparam logic [LANES-1:0] BE_ONE = LANES'(1);
    localparam logic [LANES-1:0] BE_ALL = '1;

    stk_op_e       mode;
    logic          push_en, pop_en, swap_en, call_en, ret_en;
    logic [ADDR_W-1:0] opnd_addr, dsp_addr, psp_addr;
    logic [PC_W-1:0]   acc_wide;

    // Decode the mode into the pointer enables.
    always_comb begin
        mode    = stk_op_e'(op_mode);
        push_en = op_valid && (mode == OP_PUSH);
        pop_en  = op_valid && (mode == OP_POP);
        swap_en = op_valid && (mode == OP_SWAP);
        call_en = op_valid && (mode == OP_CALL);
        ret_en  = op_valid && (mode == OP_RET);
        acc_wide = PC_W'(acc_in);
    end

    stk_operand_addr #(.AW(ADDR_W)) u_opnd (
        .base_i    (op_byte),
        .idx_i     (x_idx),
        .indexed_i (mode == OP_IDX),
        .addr_o    (opnd_addr)
    );

    stk_dsp_unit #(.AW(ADDR_W)) u_dsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_en     (push_en),
        .pop_en      (pop_en),
        .swap_en     (swap_en),
        .load_val    (acc_in),
        .dsp_q       (dsp_q),
        .access_addr (dsp_addr)
    );

    stk_psp_unit #(.AW(ADDR_W), .STEP(LANES)) u_psp (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_en    (call_en),
        .ret_en     (ret_en),
        .psp_q      (psp_q),
        .frame_addr (psp_addr)
    );

    // Drive the RAM access, strobes and side outputs for the current operation.
    always_comb begin
        ram_addr  = '0;
        ram_be    = '0;
        ram_rd    = 1'b0;
        ram_wr    = 1'b0;
        ram_wdata = '0;
        imm_valid = 1'b0;
        acc_load  = 1'b0;
        pc_load   = 1'b0;
        if (op_valid) begin
            case (mode)
                OP_IMM: imm_valid = 1'b1;
                OP_DIR, OP_IDX: begin
                    ram_addr = opnd_addr;
                    ram_be   = BE_ONE;
                    if (op_store) begin
                        ram_wr    = 1'b1;
                        ram_wdata = acc_wide;
                    end else begin
                        ram_rd = 1'b1;
                    end
                end
                OP_PUSH: begin
                    ram_addr  = dsp_addr;
                    ram_be    = BE_ONE;
                    ram_wr    = 1'b1;
                    ram_wdata = acc_wide;
                end
                OP_POP: begin
                    ram_addr = dsp_addr;
                    ram_be   = BE_ONE;
                    ram_rd   = 1'b1;
                end
                OP_CALL: begin
                    ram_addr  = psp_addr;
                    ram_be    = BE_ALL;
                    ram_wr    = 1'b1;
                    ram_wdata = pc_ret;
                end
                OP_RET: begin
                    ram_addr = psp_addr;
                    ram_be   = BE_ALL;
                    ram_rd   = 1'b1;
                    pc_load  = 1'b1;
                end
                OP_SWAP: acc_load = 1'b1;
                default: ;
            endcase
        end
    end

    // Pass-through data paths.
    always_comb begin
        imm_out    = op_byte;
        acc_out    = dsp_q;
        rd_data    = ram_rdata[DATA_W-1:0];
        pc_restore = ram_rdata;
    end

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !ram_rd && !ram_wr && !acc_load && !pc_load);
    // R2
    imm_noaccess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm_valid |-> !ram_rd && !ram_wr);
    // R3
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr));
    // R1
    reset_ptr_chk: assert property (@(posedge clk)
        !rst_n |=> dsp_q == '0 && psp_q == '0);
endmodule

// File: tb/stk_addr_unit_tb.sv
`timescale 1ns/1ps
module stk_addr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_mode = 3'd0;
    logic        op_store = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic [7:0]  x_idx = 8'h00;
    logic [7:0]  acc_in = 8'h00;
    logic [15:0] pc_ret = 16'h0000;
    logic [15:0] ram_rdata;
    logic [7:0]  ram_addr;
    logic [1:0]  ram_be;
    logic        ram_rd, ram_wr;
    logic [15:0] ram_wdata;
    logic        imm_valid, acc_load, pc_load;
    logic [7:0]  imm_out, rd_data, acc_out, dsp_q, psp_q;
    logic [15:0] pc_restore;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] mem [256];
    logic [7:0] addr_hi;

    always #2.5 clk = ~clk;

    stk_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .op_store(op_store), .op_byte(op_byte), .x_idx(x_idx), .acc_in(acc_in),
        .pc_ret(pc_ret), .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_be(ram_be),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_wdata(ram_wdata), .imm_valid(imm_valid),
        .imm_out(imm_out), .rd_data(rd_data), .acc_load(acc_load), .acc_out(acc_out),
        .pc_load(pc_load), .pc_restore(pc_restore), .dsp_q(dsp_q), .psp_q(psp_q)
    );

    // RAM model: two byte lanes, lane 1 at address+1 modulo 256.
    assign addr_hi   = ram_addr + 8'd1;
    assign ram_rdata = {mem[addr_hi], mem[ram_addr]};
    always @(posedge clk) begin
        if (ram_wr) begin
            if (ram_be[0]) mem[ram_addr] <= ram_wdata[7:0];
            if (ram_be[1]) mem[addr_hi]  <= ram_wdata[15:8];
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, then settle.
    task automatic issue(input logic [2:0] m, input logic st, input logic [7:0] b,
                         input logic [7:0] x, input logic [7:0] a, input logic [15:0] pc);
        op_valid = 1'b1; op_mode = m; op_store = st; op_byte = b;
        x_idx = x; acc_in = a; pc_ret = pc;
        #1;
    endtask

    // Let the edge take the operation, then drop valid.
    task automatic retire();
        @(negedge clk);
        op_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk(dsp_q, 8'h00, "R1 dsp reset");
        chk(psp_q, 8'h00, "R1 psp reset");
        chk({ram_rd, ram_wr}, 2'b00, "R1 no strobes");
    endtask

    task automatic t_imm();
        issue(3'd0, 1'b0, 8'h30, 8'h00, 8'h00, 16'h0);
        chk(imm_valid, 1'b1, "R2 imm_valid");
        chk(imm_out, 8'h30, "R2 imm_out");
        chk({ram_rd, ram_wr}, 2'b00, "R2 no access");
        retire();
    endtask

    task automatic t_direct();
        issue(3'd1, 1'b1, 8'h40, 8'h00, 8'h77, 16'h0);
        chk({ram_addr, ram_be, ram_wr, ram_rd}, {8'h40, 2'b01, 2'b10}, "R3 direct store");
        chk(ram_wdata[7:0], 8'h77, "R3 store data");
        retire();
        issue(3'd1, 1'b0, 8'h40, 8'h00, 8'h00, 16'h0);
        chk({ram_rd, ram_wr}, 2'b10, "R3 direct load strobes");
        chk(rd_data, 8'h77, "R3 direct load data");
        retire();
    endtask

    task automatic t_indexed();
        issue(3'd2, 1'b1, 8'h10, 8'h03, 8'h99, 16'h0);
        chk(ram_addr, 8'h13, "R4 base+x");
        chk(ram_wr, 1'b1, "R4 store strobe");
        retire();
        issue(3'd2, 1'b0, 8'hF0, 8'h23, 8'h00, 16'h0);
        chk(ram_addr, 8'h13, "R4 wrapped sum");
        chk(rd_data, 8'h99, "R4 load data");
        retire();
    endtask

    task automatic t_push_pop();
        issue(3'd3, 1'b0, 8'h00, 8'h00, 8'hA5, 16'h0);
        chk({ram_addr, ram_be, ram_wr}, {8'hFF, 2'b01, 1'b1}, "R5 push at empty wraps");
        chk(ram_wdata[7:0], 8'hA5, "R5 push data");
        retire();
        chk(dsp_q, 8'hFF, "R5 dsp after push");
        issue(3'd3, 1'b0, 8'h00, 8'h00, 8'h3C, 16'h0);
        chk(ram_addr, 8'hFE, "R5 second push");
        retire();
        issue(3'd4, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0);
        chk({ram_addr, ram_rd, ram_wr}, {8'hFE, 2'b10}, "R6 pop addr");
        chk(rd_data, 8'h3C, "R6 pop data");
        retire();
        chk(dsp_q, 8'hFF, "R6 dsp after pop");
        issue(3'd4, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0);
        chk(rd_data, 8'hA5, "R6 pop at FF");
        retire();
        chk(dsp_q, 8'h00, "R6 dsp wraps to 00");
    endtask

    task automatic t_call_ret();
        issue(3'd5, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1234);
        chk({ram_addr, ram_be, ram_wr}, {8'h00, 2'b11, 1'b1}, "R7 call write");
        chk(ram_wdata, 16'h1234, "R7 call data");
        retire();
        chk({mem[0], mem[1]}, 16'h3412, "R7 low byte first");
        chk(psp_q, 8'h02, "R7 psp +2");
        issue(3'd5, 1'b0, 8'h00, 8'h00, 8'h00, 16'hABCD);
        chk(ram_addr, 8'h02, "R7 nested call addr");
        retire();
        issue(3'd6, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0);
        chk({ram_addr, ram_be, ram_rd, pc_load}, {8'h02, 2'b11, 2'b11}, "R8 ret read");
        chk(pc_restore, 16'hABCD, "R8 inner return");
        retire();
        issue(3'd6, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0);
        chk(pc_restore, 16'h1234, "R8 outer return");
        retire();
        chk(psp_q, 8'h00, "R8 psp back to 0");
        issue(3'd6, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0);
        chk(ram_addr, 8'hFE, "R8 ret wraps");
        retire();
        chk(psp_q, 8'hFE, "R8 psp wrapped");
        issue(3'd5, 1'b0, 8'h00, 8'h00, 8'h00, 16'h5678);
        retire();
        chk(psp_q, 8'h00, "R7 call wraps to 0");
    endtask

    task automatic t_swap();
        issue(3'd7, 1'b0, 8'h00, 8'h00, 8'h20, 16'h0);
        chk({acc_load, acc_out}, {1'b1, 8'h00}, "R9 old dsp out");
        chk({ram_rd, ram_wr}, 2'b00, "R9 no access");
        retire();
        chk(dsp_q, 8'h20, "R9 dsp loaded");
        issue(3'd3, 1'b0, 8'h00, 8'h00, 8'h55, 16'h0);
        chk(ram_addr, 8'h1F, "R5 push below swapped dsp");
        retire();
        issue(3'd7, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0);
        chk(acc_out, 8'h1F, "R9 swap returns 1F");
        retire();
    endtask

    task automatic t_idle();
        op_valid = 1'b0; op_mode = 3'd3; acc_in = 8'hEE; #1;
        chk({ram_rd, ram_wr}, 2'b00, "R10 idle push no strobe");
        @(negedge clk); op_mode = 3'd5; #1;
        chk({ram_rd, ram_wr}, 2'b00, "R10 idle call no strobe");
        @(negedge clk); #1;
        chk(dsp_q, 8'h00, "R10 dsp held");
        chk(psp_q, 8'h00, "R10 psp held");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        @(negedge clk);
        t_imm();
        t_direct();
        t_indexed();
        t_push_pop();
        t_call_ret();
        t_swap();
        t_idle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule